// File: doc/BRIEF.md
# TLB Preload and Lockdown Controller

This block lets software place translation entries into a small fully associative TLB ahead of use, and lets it fence off part of that TLB. Two lockdown registers, one for the data side and one for the instruction side, each hold three fields. A base index marks the first entry that is not locked. A victim index names the slot that the next preload fills. A preserve flag is copied into an entry as its lock flag when a preload writes that entry. Register access is gated by privilege, by security state and by a secure-only enable pin.

A preload request carries a virtual page number and a side select. The block first searches the TLB. A hit ends the request at once and leaves every entry as it was. A miss sends a request to an external table walker over a valid/ready port and waits for the walker's response. A good response is written at the victim slot of the requesting side. A faulting response raises a data abort and loads the fault status and fault address outputs. While a walk is in flight the block is busy and refuses both new preloads and register accesses.

Back-pressure rules:
- Every request (register access, preload, walk request) transfers on a clock edge where its valid and its ready are both high.
- A walk request, once raised, holds its valid and its page number unchanged until the walker accepts it.
- The walker may present its response (`wk_rsp_valid`, one cycle) only after it has accepted the request. The block always takes the response in that state.
- A separate lookup port reads the TLB combinationally for observation.

Top module: `tlbpl_top`

## Requirements
- R1: A preload is accepted when `pl_valid` and `pl_ready` are high at a clock edge, and the TLB is searched at that edge. On a hit, `pl_done` and `pl_hit` pulse for one cycle in the next cycle, no walk request is raised, no entry changes and `dabort` stays low.
- R2: On a miss, `wk_req_valid` rises in the next cycle with the preload's page number. When the response arrives without a fault, the entry at the requesting side's victim index takes the page number, the physical page and a lock flag equal to that side's preserve flag. `pl_done` pulses with `pl_hit` low in the cycle after the response. On the lookup port, the lowest matching index wins.
- R3: The register word is laid out as base in bits [4:0], victim in bits [9:5] and preserve in bit [10]. `reg_side` 0 selects the data-side register and 1 selects the instruction-side register. An accepted access is answered one cycle later with `reg_ack`. A permitted read returns the word on `reg_rdata`; any other access returns 0.
- R4: A write whose victim field is below its base field stores the base value as the victim, so that victim >= base always holds.
- R5: An access with `reg_priv` low is always refused. It pulses `reg_undef` with its `reg_ack` and changes no register.
- R6: When `tl_bit` is 0, a non-secure privileged access is refused like R5. When `tl_bit` is 1 it is allowed. Secure privileged accesses are always allowed.
- R7: A data-side preload whose walk faults pulses `dabort` with `pl_done`. It loads `dfsr` with the response fault type and `dfar` with the page number, leaves `ifsr` unchanged and writes no entry.
- R8: An instruction-side preload whose walk faults pulses `dabort` with `pl_done`. It loads `dfsr` with the fixed code 5'h04, `dfar` with the page number and `ifsr` with the response fault type.
- R9: From the cycle after a missing preload is accepted until the cycle of its `pl_done`, `pl_ready` and `reg_ready` are low. Requests offered in that window are not taken. The walk request stays valid and stable until `wk_req_ready`.
- R10: Writing the preserve flag alone changes no lock flag of any existing entry.
- R11: A register write and a preload accepted at the same edge are both carried out. The preload uses the victim and preserve values held before that write.
- R12: After reset the TLB is empty, both lockdown registers read 0, `dfsr`, `dfar` and `ifsr` are 0 and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tl_bit | input | 1 | Secure-only enable for non-secure lockdown access |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register access can be taken (not busy) |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_side | input | 1 | 0 = data-side register, 1 = instruction-side register |
| reg_secure | input | 1 | Access comes from the secure state |
| reg_priv | input | 1 | Access comes from a privileged mode |
| reg_wdata | input | 11 | Write word {preserve, victim, base} |
| reg_ack | output | 1 | Access answered (one cycle) |
| reg_undef | output | 1 | Access refused as undefined (with reg_ack) |
| reg_rdata | output | 11 | Read word, valid with reg_ack |
| pl_valid | input | 1 | Preload request |
| pl_ready | output | 1 | Preload can be taken (not busy) |
| pl_side | input | 1 | 0 = data-side preload, 1 = instruction-side preload |
| pl_vpn | input | 20 | Virtual page number to preload |
| pl_done | output | 1 | Preload finished (one cycle) |
| pl_hit | output | 1 | With pl_done: the preload hit |
| dabort | output | 1 | With pl_done: the walk faulted |
| wk_req_valid | output | 1 | Walk request valid |
| wk_req_ready | input | 1 | Walker accepts the request |
| wk_req_vpn | output | 20 | Page number to walk |
| wk_rsp_valid | input | 1 | Walker response (one cycle) |
| wk_rsp_fault | input | 1 | Response is a fault |
| wk_rsp_ftype | input | 5 | Fault type of a faulting response |
| wk_rsp_ppn | input | 20 | Physical page of a good response |
| dfsr | output | 5 | Data fault status |
| dfar | output | 20 | Data fault address (page number) |
| ifsr | output | 5 | Instruction fault status |
| lk_vpn | input | 20 | Lookup port page number |
| lk_hit | output | 1 | Lookup port hit |
| lk_idx | output | 5 | Index of the lowest matching entry |
| lk_ppn | output | 20 | Physical page of that entry |
| lk_lock | output | 1 | Lock flag of that entry |

## Verification
A register write and a preload can land on the same clock edge, because both are taken whenever the block is idle. The bench provokes this by raising `reg_valid` with a new victim and preserve and `pl_valid` for a missing page in the same cycle. It judges the result by where the new entry lands and what lock flag it carries: the reference model expects the slot and flag held before the write, and also expects the write itself in a read-back. A second overlap offers a register write while a walk is pending, and the bench checks that the write is dropped.

// File: rtl/tlbpl_pkg.sv
package tlbpl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } pl_state_e;

  localparam logic SIDE_DATA  = 1'b0;
  localparam logic SIDE_INSTR = 1'b1;
endpackage

// File: rtl/tlbpl_cam.sv
module tlbpl_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] a_vpn,
  output logic             a_hit,
  input  logic [VPN_W-1:0] b_vpn,
  output logic             b_hit,
  output logic [IDX_W-1:0] b_idx,
  output logic [PPN_W-1:0] b_ppn,
  output logic             b_lock,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_lock
);
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_lock;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [ENTRIES-1:0] a_match;
  logic [ENTRIES-1:0] b_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_lock[g]  <= 1'b0;
        ent_vpn[g]   <= '0;
        ent_ppn[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_valid[g] <= 1'b1;
        ent_lock[g]  <= wr_lock;
        ent_vpn[g]   <= wr_vpn;
        ent_ppn[g]   <= wr_ppn;
      end
    end
    assign a_match[g] = ent_valid[g] && (ent_vpn[g] == a_vpn);
    assign b_match[g] = ent_valid[g] && (ent_vpn[g] == b_vpn);
  end

  assign a_hit = |a_match;

  always_comb begin
    b_hit = 1'b0;
    b_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (b_match[i]) begin
        b_hit = 1'b1;
        b_idx = IDX_W'(i);
      end
    end
  end

  assign b_ppn  = ent_ppn[b_idx];
  assign b_lock = ent_lock[b_idx];

  // R2: a written slot answers the lookup for its page from the next cycle
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && b_vpn == wr_vpn) |=> ($stable(b_vpn) -> b_hit));
endmodule

// File: rtl/tlbpl_lockdown.sv
module tlbpl_lockdown #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LD_W   = 2 * IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tl_bit,
  input  logic                  reg_fire,
  input  logic                  reg_wr,
  input  logic                  reg_side,
  input  logic                  reg_secure,
  input  logic                  reg_priv,
  input  logic [LD_W-1:0]       reg_wdata,
  output logic                  reg_ack,
  output logic                  reg_undef,
  output logic [LD_W-1:0]       reg_rdata,
  output logic [1:0][IDX_W-1:0] victim,
  output logic [1:0]            preserve
);
  logic [1:0][IDX_W-1:0] base_q;
  logic                  allowed;
  logic [IDX_W-1:0]      w_base;
  logic [IDX_W-1:0]      w_vic;
  logic                  w_pres;

  assign allowed = reg_priv && (reg_secure || tl_bit);
  assign w_base  = reg_wdata[IDX_W-1:0];
  assign w_vic   = reg_wdata[2*IDX_W-1:IDX_W];
  assign w_pres  = reg_wdata[2*IDX_W];

  for (genvar s = 0; s < 2; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[s]   <= '0;
        victim[s]   <= '0;
        preserve[s] <= 1'b0;
      end else if (reg_fire && reg_wr && allowed && reg_side == 1'(s)) begin
        base_q[s]   <= w_base;
        victim[s]   <= (w_vic < w_base) ? w_base : w_vic;
        preserve[s] <= w_pres;
      end
    end

    // R4: the victim never sits below the base
    p_victim_ge_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
      victim[s] >= base_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack   <= 1'b0;
      reg_undef <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_fire;
      reg_undef <= reg_fire && !allowed;
      if (reg_fire && allowed && !reg_wr)
        reg_rdata <= {preserve[reg_side], victim[reg_side], base_q[reg_side]};
      else
        reg_rdata <= '0;
    end
  end

  // R5: user-mode accesses are always refused
  p_user_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_fire && !reg_priv) |=> (reg_ack && reg_undef));

  // R6: the enable pin decides non-secure privileged access
  p_ns_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_fire && reg_priv && !reg_secure) |=> (reg_undef == !$past(tl_bit)));
endmodule

// File: rtl/tlbpl_fsm.sv
module tlbpl_fsm
  import tlbpl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FS_W    = 5,
  parameter logic [FS_W-1:0] ICM_CODE = 5'h04,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pl_valid,
  input  logic                  pl_side,
  input  logic [VPN_W-1:0]      pl_vpn,
  input  logic                  hit,
  input  logic [1:0][IDX_W-1:0] victim,
  input  logic [1:0]            preserve,
  output logic                  busy,
  output logic                  pl_done,
  output logic                  pl_hit,
  output logic                  dabort,
  output logic                  wk_req_valid,
  input  logic                  wk_req_ready,
  output logic [VPN_W-1:0]      wk_req_vpn,
  input  logic                  wk_rsp_valid,
  input  logic                  wk_rsp_fault,
  input  logic [FS_W-1:0]       wk_rsp_ftype,
  input  logic [PPN_W-1:0]      wk_rsp_ppn,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [VPN_W-1:0]      wr_vpn,
  output logic [PPN_W-1:0]      wr_ppn,
  output logic                  wr_lock,
  output logic [FS_W-1:0]       dfsr,
  output logic [VPN_W-1:0]      dfar,
  output logic [FS_W-1:0]       ifsr
);
  pl_state_e        state;
  logic             side_q;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] vic_q;
  logic             lock_q;
  logic             accept;
  logic             rsp_take;

  assign busy     = (state != ST_IDLE);
  assign accept   = pl_valid && !busy;
  assign rsp_take = (state == ST_WAIT) && wk_rsp_valid;

  assign wk_req_valid = (state == ST_REQ);
  assign wk_req_vpn   = vpn_q;

  assign wr_en   = rsp_take && !wk_rsp_fault;
  assign wr_idx  = vic_q;
  assign wr_vpn  = vpn_q;
  assign wr_ppn  = wk_rsp_ppn;
  assign wr_lock = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      side_q  <= SIDE_DATA;
      vpn_q   <= '0;
      vic_q   <= '0;
      lock_q  <= 1'b0;
      pl_done <= 1'b0;
      pl_hit  <= 1'b0;
      dabort  <= 1'b0;
      dfsr    <= '0;
      dfar    <= '0;
      ifsr    <= '0;
    end else begin
      pl_done <= 1'b0;
      pl_hit  <= 1'b0;
      dabort  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            side_q <= pl_side;
            vpn_q  <= pl_vpn;
            vic_q  <= victim[pl_side];
            lock_q <= preserve[pl_side];
            if (hit) begin
              pl_done <= 1'b1;
              pl_hit  <= 1'b1;
            end else begin
              state <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (wk_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wk_rsp_valid) begin
            state   <= ST_IDLE;
            pl_done <= 1'b1;
            if (wk_rsp_fault) begin
              dabort <= 1'b1;
              dfar   <= vpn_q;
              if (side_q == SIDE_INSTR) begin
                dfsr <= ICM_CODE;
                ifsr <= wk_rsp_ftype;
              end else begin
                dfsr <= wk_rsp_ftype;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a walk is only started by a preload that missed
  p_walk_on_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wk_req_valid) |-> $past(accept && !hit));

  // R1: a hit finishes next cycle quietly
  p_hit_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (pl_done && pl_hit && !dabort && !wk_req_valid));

  // R9: the walk request holds until taken
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_req_valid && !wk_req_ready) |=> (wk_req_valid && $stable(wk_req_vpn)));

  // R8: instruction-side faults carry the fixed data status code
  p_icm_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dabort && side_q == SIDE_INSTR) |-> (dfsr == ICM_CODE));
endmodule

// File: rtl/tlbpl_top.sv
module tlbpl_top #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int FS_W    = 5,
  parameter logic [FS_W-1:0] ICM_CODE = 5'h04,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LD_W   = 2 * IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tl_bit,
  input  logic             reg_valid,
  output logic             reg_ready,
  input  logic             reg_wr,
  input  logic             reg_side,
  input  logic             reg_secure,
  input  logic             reg_priv,
  input  logic [LD_W-1:0]  reg_wdata,
  output logic             reg_ack,
  output logic             reg_undef,
  output logic [LD_W-1:0]  reg_rdata,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic             pl_side,
  input  logic [VPN_W-1:0] pl_vpn,
  output logic             pl_done,
  output logic             pl_hit,
  output logic             dabort,
  output logic             wk_req_valid,
  input  logic             wk_req_ready,
  output logic [VPN_W-1:0] wk_req_vpn,
  input  logic             wk_rsp_valid,
  input  logic             wk_rsp_fault,
  input  logic [FS_W-1:0]  wk_rsp_ftype,
  input  logic [PPN_W-1:0] wk_rsp_ppn,
  output logic [FS_W-1:0]  dfsr,
  output logic [VPN_W-1:0] dfar,
  output logic [FS_W-1:0]  ifsr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_lock
);
  logic                  busy;
  logic                  a_hit;
  logic [1:0][IDX_W-1:0] victim;
  logic [1:0]            preserve;
  logic                  wr_en;
  logic [IDX_W-1:0]      wr_idx;
  logic [VPN_W-1:0]      wr_vpn;
  logic [PPN_W-1:0]      wr_ppn;
  logic                  wr_lock;

  assign reg_ready = !busy;
  assign pl_ready  = !busy;

  tlbpl_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .a_vpn(pl_vpn), .a_hit(a_hit),
    .b_vpn(lk_vpn), .b_hit(lk_hit), .b_idx(lk_idx), .b_ppn(lk_ppn), .b_lock(lk_lock),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_lock(wr_lock)
  );

  tlbpl_lockdown #(.ENTRIES(ENTRIES)) u_ld (
    .clk(clk), .rst_n(rst_n), .tl_bit(tl_bit),
    .reg_fire(reg_valid && !busy), .reg_wr(reg_wr), .reg_side(reg_side),
    .reg_secure(reg_secure), .reg_priv(reg_priv), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_undef(reg_undef), .reg_rdata(reg_rdata),
    .victim(victim), .preserve(preserve)
  );

  tlbpl_fsm #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .FS_W(FS_W),
              .ICM_CODE(ICM_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pl_valid(pl_valid), .pl_side(pl_side), .pl_vpn(pl_vpn), .hit(a_hit),
    .victim(victim), .preserve(preserve),
    .busy(busy), .pl_done(pl_done), .pl_hit(pl_hit), .dabort(dabort),
    .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready), .wk_req_vpn(wk_req_vpn),
    .wk_rsp_valid(wk_rsp_valid), .wk_rsp_fault(wk_rsp_fault),
    .wk_rsp_ftype(wk_rsp_ftype), .wk_rsp_ppn(wk_rsp_ppn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_lock(wr_lock),
    .dfsr(dfsr), .dfar(dfar), .ifsr(ifsr)
  );

  // R9: nothing is taken while a walk is pending
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_req_valid || busy) |-> (!pl_ready && !reg_ready));
endmodule

// File: tb/tlbpl_top_test.sv
module tlbpl_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tl_bit = 1'b0;
  logic reg_valid = 1'b0, reg_wr = 1'b0, reg_side = 1'b0, reg_secure = 1'b0, reg_priv = 1'b0;
  logic [10:0] reg_wdata = '0;
  logic reg_ready, reg_ack, reg_undef;
  logic [10:0] reg_rdata;
  logic pl_valid = 1'b0, pl_side = 1'b0;
  logic [19:0] pl_vpn = '0;
  logic pl_ready, pl_done, pl_hit, dabort;
  logic wk_req_valid, wk_req_ready = 1'b0;
  logic [19:0] wk_req_vpn;
  logic wk_rsp_valid = 1'b0, wk_rsp_fault = 1'b0;
  logic [4:0] wk_rsp_ftype = '0;
  logic [19:0] wk_rsp_ppn = '0;
  logic [4:0] dfsr, ifsr;
  logic [19:0] dfar;
  logic [19:0] lk_vpn = '0;
  logic lk_hit, lk_lock;
  logic [4:0] lk_idx;
  logic [19:0] lk_ppn;

  always #5 clk = ~clk;

  tlbpl_top uut (.*);

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model
  bit        m_valid [32];
  bit        m_lock  [32];
  bit [19:0] m_vpn   [32];
  bit [19:0] m_ppn   [32];
  bit [4:0]  m_base [2];
  bit [4:0]  m_vic  [2];
  bit        m_pres [2];
  bit [4:0]  m_dfsr = '0, m_ifsr = '0;
  bit [19:0] m_dfar = '0;
  bit        m_busy = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compared on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9 pl_ready", pl_ready, !m_busy);
      check("R9 reg_ready", reg_ready, !m_busy);
      check("R7 dfsr", dfsr, m_dfsr);
      check("R7 dfar", dfar, m_dfar);
      check("R8 ifsr", ifsr, m_ifsr);
    end
  end

  function automatic int m_find(bit [19:0] v);
    for (int i = 0; i < 32; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic void m_reg_write(bit side, bit [10:0] d);
    m_base[side] = d[4:0];
    m_vic[side]  = (d[9:5] < d[4:0]) ? d[4:0] : d[9:5];
    m_pres[side] = d[10];
  endfunction

  task automatic lookup(string tag, bit [19:0] v);
    int idx;
    lk_vpn = v;
    #1;
    idx = m_find(v);
    check({tag, " lk_hit"}, lk_hit, idx >= 0);
    if (idx >= 0) begin
      check({tag, " lk_idx"}, lk_idx, idx);
      check({tag, " lk_ppn"}, lk_ppn, m_ppn[idx]);
      check({tag, " lk_lock"}, lk_lock, m_lock[idx]);
    end
  endtask

  // register access (R3, R5, R6)
  task automatic reg_op(string tag, bit wr, bit side, bit sec, bit priv, bit [10:0] d);
    bit allowed;
    bit [10:0] exp_rd;
    @(negedge clk);
    reg_valid = 1'b1; reg_wr = wr; reg_side = side;
    reg_secure = sec; reg_priv = priv; reg_wdata = d;
    @(posedge clk);
    #1 reg_valid = 1'b0;
    allowed = priv && (sec || tl_bit);
    exp_rd = (allowed && !wr) ? {m_pres[side], m_vic[side], m_base[side]} : 11'd0;
    if (allowed && wr) m_reg_write(side, d);
    @(negedge clk);
    check({tag, " reg_ack"}, reg_ack, 1);
    check({tag, " reg_undef"}, reg_undef, !allowed);
    check({tag, " reg_rdata"}, reg_rdata, exp_rd);
  endtask

  // preload (R1, R2, R7, R8, R9, R11)
  task automatic preload(string tag, bit side, bit [19:0] v, bit flt, bit [4:0] ft,
                         bit [19:0] ppn, int delay, bit poke, bit with_reg, bit [10:0] rd);
    bit hit;
    bit [4:0] vic;
    bit pres;
    @(negedge clk);
    pl_valid = 1'b1; pl_side = side; pl_vpn = v;
    if (with_reg) begin
      reg_valid = 1'b1; reg_wr = 1'b1; reg_side = side;
      reg_secure = 1'b1; reg_priv = 1'b1; reg_wdata = rd;
    end
    @(posedge clk);
    #1 pl_valid = 1'b0; reg_valid = 1'b0;
    hit = (m_find(v) >= 0);
    vic = m_vic[side];
    pres = m_pres[side];
    if (with_reg) m_reg_write(side, rd);
    if (hit) begin
      @(negedge clk);
      check({tag, " R1 done"}, pl_done, 1);
      check({tag, " R1 hit"}, pl_hit, 1);
      check({tag, " R1 no abort"}, dabort, 0);
      check({tag, " R1 no walk"}, wk_req_valid, 0);
      if (with_reg) check({tag, " R11 reg_ack"}, reg_ack, 1);
      return;
    end
    m_busy = 1'b1;
    @(negedge clk);
    check({tag, " R2 walk req"}, wk_req_valid, 1);
    check({tag, " R2 walk vpn"}, wk_req_vpn, v);
    check({tag, " R2 no done"}, pl_done, 0);
    if (with_reg) check({tag, " R11 reg_ack"}, reg_ack, 1);
    for (int k = 0; k < delay; k++) begin
      if (poke) begin
        reg_valid = 1'b1; reg_wr = 1'b1; reg_side = side;
        reg_secure = 1'b1; reg_priv = 1'b1; reg_wdata = 11'h7FF;
        pl_valid = 1'b1; pl_vpn = v ^ 20'h1;
      end
      @(negedge clk);
      check({tag, " R9 req held"}, wk_req_valid, 1);
      check({tag, " R9 vpn held"}, wk_req_vpn, v);
      check({tag, " R9 no ack"}, reg_ack, 0);
      check({tag, " R9 no done"}, pl_done, 0);
    end
    reg_valid = 1'b0; pl_valid = 1'b0;
    wk_req_ready = 1'b1;
    @(posedge clk);
    #1 wk_req_ready = 1'b0;
    @(negedge clk);
    check({tag, " R9 req dropped"}, wk_req_valid, 0);
    wk_rsp_valid = 1'b1; wk_rsp_fault = flt; wk_rsp_ftype = ft; wk_rsp_ppn = ppn;
    @(posedge clk);
    #1 wk_rsp_valid = 1'b0;
    m_busy = 1'b0;
    if (flt) begin
      m_dfar = v;
      if (side) begin m_dfsr = 5'h04; m_ifsr = ft; end
      else m_dfsr = ft;
    end else begin
      m_valid[vic] = 1'b1; m_vpn[vic] = v; m_ppn[vic] = ppn; m_lock[vic] = pres;
    end
    @(negedge clk);
    check({tag, " R2 done"}, pl_done, 1);
    check({tag, " R2 hit low"}, pl_hit, 0);
    check({tag, flt ? (side ? " R8 abort" : " R7 abort") : " R2 no abort"}, dabort, flt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    for (int s = 0; s < 2; s++) begin m_base[s] = 0; m_vic[s] = 0; m_pres[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    check("R12 pl_ready", pl_ready, 1);
    check("R12 reg_ready", reg_ready, 1);
    check("R12 dfsr", dfsr, 0);
    check("R12 ifsr", ifsr, 0);
    lookup("R12 empty", 20'h12345);
    reg_op("R12 read d", 0, 0, 1, 1, 0);
    reg_op("R12 read i", 0, 1, 1, 1, 0);

    // R5 user access refused
    reg_op("R5 user write", 1, 0, 1, 0, {1'b1, 5'd3, 5'd0});
    reg_op("R5 user read", 0, 0, 1, 0, 0);
    reg_op("R5 readback", 0, 0, 1, 1, 0);

    // R6 non-secure gating
    tl_bit = 1'b0;
    reg_op("R6 ns write tl0", 1, 0, 0, 1, {1'b1, 5'd3, 5'd0});
    reg_op("R6 readback", 0, 0, 1, 1, 0);
    tl_bit = 1'b1;
    reg_op("R6 ns write tl1", 1, 0, 0, 1, {1'b1, 5'd3, 5'd0});
    reg_op("R6 R3 ns read tl1", 0, 0, 0, 1, 0);
    tl_bit = 1'b0;

    // R4 victim clamp, R3 side select
    reg_op("R4 clamp write", 1, 1, 1, 1, {1'b0, 5'd2, 5'd6});
    reg_op("R4 R3 read i", 0, 1, 1, 1, 0);
    reg_op("R3 write i", 1, 1, 1, 1, {1'b0, 5'd7, 5'd0});
    reg_op("R3 read d", 0, 0, 1, 1, 0);

    // R2 + R9 miss with walker back-pressure and blocked requests
    preload("R2 d miss", 0, 20'h12345, 0, 0, 20'hABCDE, 3, 1, 0, 0);
    lookup("R2 d entry", 20'h12345);
    reg_op("R9 reg untouched", 0, 0, 1, 1, 0);
    lookup("R9 poke preload absent", 20'h12344);

    // R1 hit
    preload("R1 d hit", 0, 20'h12345, 0, 0, 0, 0, 0, 0, 0);
    preload("R1 i hit shared", 1, 20'h12345, 0, 0, 0, 0, 0, 0, 0);
    lookup("R1 entry unchanged", 20'h12345);

    // R2 instruction side
    preload("R2 i miss", 1, 20'h00777, 0, 0, 20'h11111, 0, 0, 0, 0);
    lookup("R2 i entry", 20'h00777);

    // R7 / R8 faults
    preload("R7 d fault", 0, 20'h0BEEF, 1, 5'h0D, 0, 1, 0, 0, 0);
    lookup("R7 no entry", 20'h0BEEF);
    lookup("R7 victim kept", 20'h12345);
    preload("R8 i fault", 1, 20'h0CAFE, 1, 5'h07, 0, 0, 0, 0, 0);
    lookup("R8 no entry", 20'h0CAFE);

    // R10 preserve write alone leaves entries as they are
    reg_op("R10 clear preserve", 1, 0, 1, 1, {1'b0, 5'd3, 5'd0});
    lookup("R10 lock kept", 20'h12345);

    // R11 same-cycle write and preload
    reg_op("R11 setup", 1, 0, 1, 1, {1'b0, 5'd5, 5'd1});
    preload("R11 overlap", 0, 20'h55555, 0, 0, 20'h22222, 0, 0, 1, {1'b1, 5'd9, 5'd1});
    lookup("R11 old victim used", 20'h55555);
    reg_op("R11 write landed", 0, 0, 1, 1, 0);
    preload("R11 new victim", 0, 20'h66666, 0, 0, 20'h33333, 1, 0, 0, 0);
    lookup("R11 new victim used", 20'h66666);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule